// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that sits on a simple 32-bit bus with word-indexed read and write strobes. Software puts a word into a one-entry transmit holding register. The block moves that word into a shifter and sends it out MSB first on the serial clock and data-out lines. At the same time it shifts in the data-in line. When the word is complete, the received value goes into a one-entry receive register, and a ready flag is raised in the status word.

Two sticky error flags record lost data. One records a received word that overwrote an unread one. The other records a transmit write that arrived while the holding register was still full. A summary error bit is the OR of the two. The control word holds one interrupt enable for each status condition, and the interrupt line is the OR of every enabled, raised flag.

The slave-select outputs are active low, and a programmable mask chooses which of them to drive. Normally they frame each word. A force bit keeps them asserted between words, so that a multi-word transaction stays inside one select window. Word width, clock polarity, clock phase and the clock divider are parameters.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the status word (word index 2) reads 0x060, with transmit-ready (bit 6) and shifter-empty (bit 5) set. After reset the interrupt output is low, all select outputs are high and the serial clock sits at CPOL.
- R2: A write to word index 1 while transmit-ready is set starts a transfer. The word is shifted out MSB first; in mode 0, data-out changes on falling clock edges and data-in is sampled on rising edges. When the transfer ends, the received word reads at word index 0 and receive-ready (status bit 7) is set.
- R3: With the force bit clear, select line i is low only while a word is being shifted and only if bit i of the mask (word index 5) is set. It falls CLK_DIV clock cycles before the first serial clock edge and rises CLK_DIV cycles after the last edge.
- R4: With control bit 10 set, the masked select lines stay low while the shifter is idle. A mask of zero drives all select lines high.
- R5: Reading word index 0 clears receive-ready.
- R6: If a word completes while receive-ready is still set, the receive-overrun flag (status bit 3) is set and the newer word replaces the old one.
- R7: A write to word index 1 while transmit-ready is low sets the transmit-overrun flag (status bit 4). The written word is never sent.
- R8: Status bit 8 reads as the OR of bits 3 and 4.
- R9: Any write to word index 2 clears both overrun flags.
- R10: The interrupt output is high exactly when some status bit among 3, 4, 6, 7 and 8 is set together with the same bit of the control word (word index 3).
- R11: Transmit-ready stays high while a word shifts and the holding register is empty, so a second word can be queued. Shifter-empty is high only when the holding register and the shifter are both empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of index 0 consumes the word) |
| addr | input | 3 | Word index: 0 rx, 1 tx, 2 status, 3 control, 5 select mask |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSLAVE | Active-low slave selects |

## Verification
The bench sends words with alternating, all-zero, all-one and edge-bit patterns. These show a bit-order or shift-timing fault that a single symmetric value would hide. The slave model returns a different pattern for each word, so a received word that was stale or misaligned cannot match by chance. Back-to-back writes separate the two ready flags and test overwrite-on-overrun. A triple write shows that the rejected word never reaches the wire. The force-select runs and the zero-mask runs check the select line's idle level, apart from the framing the engine gives each word.

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int DATA_W  = 8,
  parameter int NSLAVE  = 4,
  parameter int CLK_DIV = 2,
  parameter bit CPOL    = 1'b0,
  parameter bit CPHA    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NSLAVE-1:0] ss_n
);
  localparam int HW  = $clog2(2*DATA_W+2);
  localparam int DVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [2:0] A_RX = 3'd0, A_TX = 3'd1, A_ST = 3'd2, A_CT = 3'd3, A_SS = 3'd5;
  localparam logic [HW-1:0] EDGES = HW'(2*DATA_W);

  logic [DATA_W-1:0] txbuf, tx_sh, rx_sh, rxbuf;
  logic              txfull, busy, rrdy, roe, toe;
  logic [HW-1:0]     hp;
  logic [DVW-1:0]    div;
  logic [10:0]       ctrl;
  logic [NSLAVE-1:0] ssmask;

  wire tx_wr = wr_en && addr == A_TX;
  wire rx_rd = rd_en && addr == A_RX;
  wire tick  = busy && div == DVW'(CLK_DIV-1);
  wire [HW-1:0] hn = hp + 1'b1;
  wire in_edges = hn <= EDGES;
  wire last  = tick && hn == EDGES + 1'b1;
  wire samp  = tick && in_edges && (CPHA ? !hn[0] : hn[0]);
  wire shft  = tick && hn < EDGES && (CPHA ? (hn[0] && hn != 1) : !hn[0]);

  wire [8:0] st = {roe | toe, rrdy, !txfull, !txfull && !busy, toe, roe, 3'b000};

  assign irq  = |(st & ctrl[8:0]);
  assign sclk = CPOL ^ (busy & hp[0]);
  assign mosi = tx_sh[DATA_W-1];
  assign ss_n = ~(ssmask & {NSLAVE{busy | ctrl[10]}});

  always_comb begin
    rdata = '0;
    case (addr)
      A_RX: rdata[DATA_W-1:0] = rxbuf;
      A_ST: rdata[8:0] = st;
      A_CT: rdata[10:0] = ctrl;
      A_SS: rdata[NSLAVE-1:0] = ssmask;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf <= '0; tx_sh <= '0; rx_sh <= '0; rxbuf <= '0;
      txfull <= 1'b0; busy <= 1'b0; rrdy <= 1'b0; roe <= 1'b0; toe <= 1'b0;
      hp <= '0; div <= '0; ctrl <= '0; ssmask <= '0;
    end else begin
      if (wr_en && addr == A_CT) ctrl <= wdata[10:0] & 11'h5D8;
      if (wr_en && addr == A_SS) ssmask <= wdata[NSLAVE-1:0];
      if (tx_wr) begin
        if (txfull) toe <= 1'b1;
        else begin
          txbuf  <= wdata[DATA_W-1:0];
          txfull <= 1'b1;
        end
      end
      if (rx_rd) rrdy <= 1'b0;
      if (!busy && txfull) begin
        busy   <= 1'b1;
        tx_sh  <= txbuf;
        txfull <= 1'b0;
        hp     <= '0;
        div    <= '0;
      end else if (busy) begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) hp <= hn;
        if (samp) rx_sh <= {rx_sh[DATA_W-2:0], miso};
        if (shft) tx_sh <= tx_sh << 1;
        if (last) begin
          busy  <= 1'b0;
          rxbuf <= rx_sh;
          rrdy  <= 1'b1;
          if (rrdy && !rx_rd) roe <= 1'b1;
        end
      end
      if (wr_en && addr == A_ST) begin
        roe <= 1'b0;
        toe <= 1'b0;
      end
    end
  end
endmodule

module spi_host_regs_chk #(
  parameter int NSLAVE = 4,
  parameter bit CPOL   = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [2:0]        addr,
  input logic              busy,
  input logic              txfull,
  input logic              rrdy,
  input logic              roe,
  input logic              toe,
  input logic              sso,
  input logic              sclk,
  input logic [NSLAVE-1:0] ss_n
);
  assert_rrdy_after_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rrdy) |-> $past(busy) && !busy);
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == CPOL);
  assert_ss_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sso) |-> &ss_n);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0 && !busy) |=> !rrdy);
  assert_roe_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(roe) |-> $past(rrdy));
  assert_toe_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && txfull && !(wr_en && addr == 3'd2)) |=> toe);
  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> !roe && !toe);
endmodule

bind spi_host_regs spi_host_regs_chk #(.NSLAVE(NSLAVE), .CPOL(CPOL)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .busy(busy), .txfull(txfull), .rrdy(rrdy), .roe(roe), .toe(toe),
  .sso(ctrl[10]), .sclk(sclk), .ss_n(ss_n));

// File: tb/test_spi_host_regs.sv
module test_spi_host_regs;
  localparam int CLK_DIV = 2;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, miso;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, sclk, mosi;
  logic [3:0] ss_n;

  spi_host_regs #(.DATA_W(8), .NSLAVE(4), .CLK_DIV(CLK_DIV)) i_spi_host_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  always #10 clk = ~clk;

  int n_cmp = 0, n_err = 0, n_sent = 0;
  logic [7:0] exp_q[$];

  function automatic logic [7:0] pat(int k);
    return 8'(60 + k * 41);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic send(logic [7:0] d, bit accepted);
    if (accepted) begin exp_q.push_back(d); n_sent++; end
    wr(3'd1, {24'd0, d});
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(3'd2, s); while (!s[5]);
  endtask

  // slave model and scoreboard monitor
  logic [7:0] s_out, cap;
  int scnt = 0, sidx = 0;
  bit sflag = 0;
  initial s_out = pat(0);
  assign miso = s_out[7];
  always @(posedge sclk) begin
    cap = {cap[6:0], mosi};
    scnt++;
    if (scnt == 8) begin
      scnt = 0; sflag = 1;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_err++; $display("FAIL R2/R7 act=%h exp=<none>", cap);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (cap !== e) begin n_err++; $display("FAIL R2 mosi act=%h exp=%h", cap, e); end
      end
    end
  end
  always @(negedge sclk) begin
    if (sflag) begin sflag = 0; sidx++; s_out = pat(sidx); end
    else s_out = s_out << 1;
  end

  // select framing monitor
  int cyc = 0, t_ssf = -1, t_rise = -1, t_fall = -1, t_ssr = -1;
  bit p_ss = 1, p_sclk = 0;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (p_ss && !(&ss_n) && t_ssf < 0) t_ssf = cyc;
    if (!p_sclk && sclk && t_rise < 0 && t_ssf >= 0) t_rise = cyc;
    if (p_sclk && !sclk && t_ssr < 0) t_fall = cyc;
    if (!p_ss && (&ss_n) && t_ssr < 0 && t_ssf >= 0) t_ssr = cyc;
    p_ss = &ss_n; p_sclk = sclk;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(3'd2, d); chk("R1 status", d, 32'h060);
    chk("R1 irq", irq, 0); chk("R1 ss_n", ss_n, 4'hF); chk("R1 sclk", sclk, 0);
    rst_n = 1'b1;
    rd(3'd2, d); chk("R1 status after release", d, 32'h060);

    // R2/R3 single word
    wr(3'd5, 32'h2);
    send(8'hA5, 1);
    repeat (3) @(negedge clk);
    chk("R3 ss_n during word", ss_n, 4'b1101);
    rd(3'd2, d); chk("R11 trdy high, tmt low while shifting", d[6:5], 2'b10);
    wait_idle();
    chk("R3 lead cycles", t_rise - t_ssf, CLK_DIV);
    chk("R3 trail cycles", t_ssr - t_fall, CLK_DIV);
    rd(3'd2, d); chk("R2 rrdy set", d[7], 1);
    rd(3'd0, d); chk("R2 rx word", d, {24'd0, pat(0)});
    rd(3'd2, d); chk("R5 rrdy cleared by read", d, 32'h060);

    // R2 several patterns
    foreach (d[i]) if (i < 3) begin
      logic [7:0] v;
      logic [31:0] r;
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'h81;
      send(v, 1);
      wait_idle();
      rd(3'd0, r); chk("R2 rx pattern", r, {24'd0, pat(n_sent - 1)});
    end

    // R6/R8/R10 overrun with back-to-back words
    send(8'h55, 1);
    send(8'h66, 1);
    rd(3'd2, d); chk("R11 second word queued, trdy low", d[6:5], 2'b00);
    wait_idle();
    rd(3'd2, d); chk("R6 R8 status after overrun", d, 32'h1E8);
    chk("R10 irq off when masked", irq, 0);
    wr(3'd3, 32'h8);
    chk("R10 irq on roe enable", irq, 1);
    rd(3'd0, d); chk("R6 newer word kept", d, {24'd0, pat(n_sent - 1)});
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R9 flags cleared", d, 32'h060);
    chk("R10 irq low after clear", irq, 0);

    // R7 transmit overrun
    wr(3'd3, 32'h10);
    send(8'h3A, 1);
    send(8'hC4, 1);
    send(8'hEE, 0);
    rd(3'd2, d); chk("R7 R8 toe and summary", d & 32'h110, 32'h110);
    chk("R10 irq on toe enable", irq, 1);
    wait_idle();
    rd(3'd0, d); chk("R7 last word is accepted one", d, {24'd0, pat(n_sent - 1)});
    wr(3'd2, 32'h0);
    chk("R10 irq low after clear", irq, 0);

    // R10 rrdy interrupt
    wr(3'd3, 32'h80);
    send(8'h17, 1);
    wait_idle();
    chk("R10 irq on rrdy", irq, 1);
    rd(3'd0, d);
    chk("R10 irq drops after read", irq, 0);

    // R4 force select
    wr(3'd3, 32'h400);
    wr(3'd5, 32'h1);
    chk("R4 forced low while idle", ss_n, 4'b1110);
    send(8'hB2, 1);
    send(8'h4D, 1);
    wait_idle();
    chk("R4 still low between words", ss_n, 4'b1110);
    rd(3'd0, d); chk("R2 rx under force", d, {24'd0, pat(n_sent - 1)});
    wr(3'd5, 32'h0);
    chk("R4 zero mask deasserts", ss_n, 4'hF);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h0);

    repeat (4) @(negedge clk);
    chk("R7 no leftover expected words", exp_q.size(), 0);
    rd(3'd2, d); chk("R11 idle status", d, 32'h060);
    summary();
  end
endmodule